// File: doc/BRIEF.md
# Exact-Match Key Lookup Table

This block holds a small table of keys, each tied to a data word, and answers the question "which entry holds this key, and what data goes with it?" in a single search. Every stored key is compared with the search key at the same moment. A row counts as matching only when all of its key bits are equal to the search bits and the row is marked valid. The matching rows select a word in a companion data store. That word is returned together with the row number and a hit flag.

A routing or translation path loads entries through the write port, which sets the key, the data word and the valid flag of one row together. It removes entries through the invalidate port. It issues lookups on the search port. When several rows hold the same key, the lowest-numbered row wins. Results are registered and appear in the cycle after the request.

Top module: `keymatch_lookup`

## Requirements
- R1: After synchronous reset every row is invalid, and the result outputs are low or zero: `res_valid`, `res_hit`, `res_idx` and `res_data`.
- R2: A write with `wr_en` high loads `wr_key`, `wr_data` and a set valid flag into row `wr_idx`. A later search for that key then returns hit, that index and that data word.
- R3: A row matches only when every key bit equals the search bit. A key that differs in any single bit position, the lowest and the highest included, misses.
- R4: With `inv_en` high, row `inv_idx` becomes invalid, and invalid rows never match.
- R5: When several valid rows match, the result reports the lowest matching index and that row's data word.
- R6: `res_valid` is high in exactly the cycle after a cycle with `srch_en` high, and low after a cycle without a search. `res_hit` is never high while `res_valid` is low.
- R7: On a miss, `res_hit` is 0, `res_idx` is 0 and `res_data` is 0.
- R8: A search in the same cycle as a write sees the table as it was before that write: the old data word, or a miss for a key not yet stored. The next search sees the new contents.
- R9: When a write and an invalidate name the same row in one cycle, the row ends invalid.
- R10: All rows are compared in one search, so the highest row, `ENTRIES-1`, returns a hit with the same one-cycle latency as row 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Load key, data and valid flag into a row |
| wr_idx | input | IDX_W | Row to load |
| wr_key | input | KEY_W | Key to store |
| wr_data | input | DATA_W | Data word to store |
| inv_en | input | 1 | Clear the valid flag of a row |
| inv_idx | input | IDX_W | Row to invalidate |
| srch_en | input | 1 | Search request |
| srch_key | input | KEY_W | Key to look up |
| res_valid | output | 1 | Result of the previous cycle's search is present |
| res_hit | output | 1 | At least one valid row matched |
| res_idx | output | IDX_W | Lowest matching row, 0 on a miss |
| res_data | output | DATA_W | Data word of that row, 0 on a miss |

## Verification
Table updates and searches can fall in the same cycle. So can a load and an invalidate aimed at the same row. The bench drives a write of new data to a stored key together with a search for that key, and expects the old word. It does the same with a write of a brand-new key, and expects a miss. A following search must then return the new contents. A combined load and invalidate of one row is judged by a later search, which must miss.

// File: rtl/kml_pkg.sv
`timescale 1ns/1ps
package kml_pkg;
  typedef enum logic [1:0] {
    ROW_HOLD = 2'd0,
    ROW_LOAD = 2'd1,
    ROW_DROP = 2'd2
  } row_op_e;
endpackage

// File: rtl/kml_key_rows.sv
`timescale 1ns/1ps
module kml_key_rows #(
  parameter int ENTRIES = 8,
  parameter int KEY_W   = 16,
  parameter int IDX_W   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [KEY_W-1:0]   wr_key,
  input  logic               inv_en,
  input  logic [IDX_W-1:0]   inv_idx,
  input  logic [KEY_W-1:0]   srch_key,
  output logic [ENTRIES-1:0] match_o
);
  import kml_pkg::*;

  for (genvar r = 0; r < ENTRIES; r++) begin : g_row
    row_op_e          op;
    logic             valid_q;
    logic [KEY_W-1:0] key_q;

    // invalidate has priority over a load to the same row
    always_comb begin
      op = ROW_HOLD;
      if (inv_en && inv_idx == IDX_W'(r))      op = ROW_DROP;
      else if (wr_en && wr_idx == IDX_W'(r))   op = ROW_LOAD;
    end

    always_ff @(posedge clk) begin
      if (rst) valid_q <= 1'b0;
      else if (op == ROW_LOAD) valid_q <= 1'b1;
      else if (op == ROW_DROP) valid_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
      if (op == ROW_LOAD) key_q <= wr_key;
    end

    // per-bit XOR, any mismatch kills the row's match line
    assign match_o[r] = valid_q & ~(|(key_q ^ srch_key));

    p_drop_clears_r4: assert property (@(posedge clk) disable iff (rst)
      (inv_en && inv_idx == IDX_W'(r)) |=> !valid_q);

    p_load_stores_r2: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_idx == IDX_W'(r) && !(inv_en && inv_idx == IDX_W'(r)))
        |=> (valid_q && key_q == $past(wr_key)));

    p_same_row_drop_r9: assert property (@(posedge clk) disable iff (rst)
      (wr_en && inv_en && wr_idx == IDX_W'(r) && inv_idx == IDX_W'(r)) |=> !valid_q);
  end
endmodule

// File: rtl/kml_pick.sv
`timescale 1ns/1ps
module kml_pick #(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = 3
) (
  input  logic [ENTRIES-1:0] match_i,
  output logic               any_o,
  output logic [IDX_W-1:0]   idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match_i[i]) idx_o = IDX_W'(i);
    end
    any_o = |match_i;
  end

  always_comb begin
    if (any_o) begin
      p_pick_lowest_r5: assert (match_i[idx_o] &&
        ((match_i & ((ENTRIES'(1) << idx_o) - ENTRIES'(1))) == '0));
    end
  end
endmodule

// File: rtl/kml_data_ram.sv
`timescale 1ns/1ps
module kml_data_ram #(
  parameter int ENTRIES = 8,
  parameter int DATA_W  = 12,
  parameter int IDX_W   = 3
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [ENTRIES];

  // read-first: a read in the write cycle returns the old word
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
    if (rd_en) rd_data <= mem[rd_idx];
  end
endmodule

// File: rtl/keymatch_lookup.sv
`timescale 1ns/1ps
module keymatch_lookup #(
  parameter int ENTRIES = 8,
  parameter int KEY_W   = 16,
  parameter int DATA_W  = 12,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [KEY_W-1:0]  wr_key,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              inv_en,
  input  logic [IDX_W-1:0]  inv_idx,
  input  logic              srch_en,
  input  logic [KEY_W-1:0]  srch_key,
  output logic              res_valid,
  output logic              res_hit,
  output logic [IDX_W-1:0]  res_idx,
  output logic [DATA_W-1:0] res_data
);
  logic [ENTRIES-1:0] match_lines;
  logic               any_match;
  logic [IDX_W-1:0]   win_idx;
  logic [DATA_W-1:0]  ram_q;

  kml_key_rows #(.ENTRIES(ENTRIES), .KEY_W(KEY_W), .IDX_W(IDX_W)) u_rows (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_key(wr_key),
    .inv_en(inv_en), .inv_idx(inv_idx),
    .srch_key(srch_key), .match_o(match_lines)
  );

  kml_pick #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_pick (
    .match_i(match_lines), .any_o(any_match), .idx_o(win_idx)
  );

  kml_data_ram #(.ENTRIES(ENTRIES), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_ram (
    .clk(clk),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_en(srch_en), .rd_idx(win_idx), .rd_data(ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_idx   <= '0;
    end else begin
      res_valid <= srch_en;
      res_hit   <= srch_en & any_match;
      res_idx   <= (srch_en & any_match) ? win_idx : '0;
    end
  end

  assign res_data = res_hit ? ram_q : '0;

  p_resp_after_req_r6: assert property (@(posedge clk) disable iff (rst)
    srch_en |=> res_valid);
  p_no_resp_idle_r6: assert property (@(posedge clk) disable iff (rst)
    !srch_en |=> !res_valid);
  p_hit_has_req_r6: assert property (@(posedge clk) disable iff (rst)
    res_hit |-> res_valid);
endmodule

// File: tb/tb_keymatch_lookup.sv
`timescale 1ns/1ps
module tb_keymatch_lookup;
  localparam int ENTRIES = 8;
  localparam int KEY_W   = 16;
  localparam int DATA_W  = 12;
  localparam int IDX_W   = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, inv_en = 1'b0, srch_en = 1'b0;
  logic [IDX_W-1:0]  wr_idx = '0, inv_idx = '0;
  logic [KEY_W-1:0]  wr_key = '0, srch_key = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic              res_valid, res_hit;
  logic [IDX_W-1:0]  res_idx;
  logic [DATA_W-1:0] res_data;

  int n_checks = 0;
  int n_fails  = 0;

  always #2.5 clk = ~clk;

  keymatch_lookup #(.ENTRIES(ENTRIES), .KEY_W(KEY_W), .DATA_W(DATA_W)) dut (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_key(wr_key), .wr_data(wr_data),
    .inv_en(inv_en), .inv_idx(inv_idx),
    .srch_en(srch_en), .srch_key(srch_key),
    .res_valid(res_valid), .res_hit(res_hit), .res_idx(res_idx), .res_data(res_data)
  );

  function automatic logic [KEY_W-1:0] key_of(int i);
    return 16'hA000 ^ KEY_W'(i * 16'h0111);
  endfunction
  function automatic logic [DATA_W-1:0] data_of(int i);
    return DATA_W'(12'h100 + i * 3);
  endfunction

  task automatic chk(string req, string what, longint act, longint exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic write_row(int idx, logic [KEY_W-1:0] k, logic [DATA_W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = IDX_W'(idx); wr_key = k; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic drop_row(int idx);
    @(negedge clk);
    inv_en = 1'b1; inv_idx = IDX_W'(idx);
    @(negedge clk);
    inv_en = 1'b0;
  endtask

  task automatic search(string req, logic [KEY_W-1:0] k, logic hit, int idx, logic [DATA_W-1:0] d);
    @(negedge clk);
    srch_en = 1'b1; srch_key = k;
    @(negedge clk);
    srch_en = 1'b0;
    chk(req, "valid", res_valid, 1);
    chk(req, "hit", res_hit, hit);
    chk(req, "idx", res_idx, hit ? idx : 0);
    chk(req, "data", res_data, hit ? d : 0);
  endtask

  task automatic t_reset;
    chk("R1", "valid after reset", res_valid, 0);
    chk("R1", "hit after reset", res_hit, 0);
    chk("R1", "data after reset", res_data, 0);
    search("R1", 16'h0000, 1'b0, 0, '0);
    search("R7", key_of(3), 1'b0, 0, '0);
  endtask

  task automatic t_fill_and_find;
    for (int i = 0; i < ENTRIES; i++) write_row(i, key_of(i), data_of(i));
    for (int i = 0; i < ENTRIES; i++) search("R2", key_of(i), 1'b1, i, data_of(i));
    search("R10", key_of(ENTRIES - 1), 1'b1, ENTRIES - 1, data_of(ENTRIES - 1));
  endtask

  task automatic t_bit_flip;
    search("R3", key_of(3) ^ 16'h0001, 1'b0, 0, '0);
    search("R3", key_of(3) ^ 16'h8000, 1'b0, 0, '0);
    search("R7", key_of(3) ^ 16'h0100, 1'b0, 0, '0);
  endtask

  task automatic t_latency;
    @(negedge clk);
    srch_en = 1'b1; srch_key = key_of(4);
    @(negedge clk);
    srch_en = 1'b0;
    chk("R6", "valid next cycle", res_valid, 1);
    @(negedge clk);
    chk("R6", "valid idle", res_valid, 0);
    chk("R6", "hit idle", res_hit, 0);
  endtask

  task automatic t_priority;
    write_row(5, key_of(2), 12'h5A5);
    search("R5", key_of(2), 1'b1, 2, data_of(2));
    drop_row(2);
    search("R4", key_of(2), 1'b1, 5, 12'h5A5);
    drop_row(5);
    search("R4", key_of(2), 1'b0, 0, '0);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 3'd6; wr_key = key_of(6); wr_data = 12'hABC;
    srch_en = 1'b1; srch_key = key_of(6);
    @(negedge clk);
    wr_en = 1'b0; srch_en = 1'b0;
    chk("R8", "old data", res_data, data_of(6));
    chk("R8", "old idx", res_idx, 6);
    search("R8", key_of(6), 1'b1, 6, 12'hABC);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 3'd7; wr_key = 16'h1234; wr_data = 12'h777;
    srch_en = 1'b1; srch_key = 16'h1234;
    @(negedge clk);
    wr_en = 1'b0; srch_en = 1'b0;
    chk("R8", "new key not yet seen", res_hit, 0);
    search("R8", 16'h1234, 1'b1, 7, 12'h777);
  endtask

  task automatic t_load_drop_clash;
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 3'd1; wr_key = key_of(1); wr_data = 12'h0EE;
    inv_en = 1'b1; inv_idx = 3'd1;
    @(negedge clk);
    wr_en = 1'b0; inv_en = 1'b0;
    search("R9", key_of(1), 1'b0, 0, '0);
  endtask

  initial begin
    #(5.0 * 100000);
    n_checks++; n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_fill_and_find();
    t_bit_flip();
    t_latency();
    t_priority();
    t_same_cycle();
    t_load_drop_clash();
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule